// File: doc/BRIEF.md
# Eight-Channel Software/Hardware Started Transfer Engine

This block is a small transfer engine with eight independent channels. Each channel holds its own source and destination addresses, a transfer count and a mode byte. A channel is armed by a one-cycle pulse on its hardware request input, or by software writing a one to that channel's bit in the request register. Once armed, the channel issues transfers on a memory request port. Each transfer moves one item of 1, 2 or 4 bytes from the source address to the destination address. The memory side carries out the move and accepts the request with a valid/ready handshake.

A start normally produces one transfer. The channel's request bit then clears itself, and software can re-arm the channel while its count is not zero. When the burst flag is set in a channel's mode byte, one start instead drives back-to-back transfers until the count reaches zero. When several channels are armed, the lowest-numbered one is served first. A channel whose count is zero cannot be armed. The cycle after the transfer that brings a count to zero, the channel raises a one-cycle done pulse.

The memory request port follows valid/ready rules. `mem_valid` is held, with a constant payload, until `mem_ready` is seen high on a rising edge. The transfer counts as done on that edge. The memory side may hold `mem_ready` low for any number of cycles. It may also drive `mem_ready` high before `mem_valid` rises. Configuration and the request lines are plain control pins.

Top module: `udma_engine`

## Requirements
- R1: After reset the request register reads 0, `mem_valid` is 0 and `done` is 0. All channel registers read 0.
- R2: Configuration address map. Address bit 5 = 1 selects the request register. Otherwise bits 4:2 pick the channel and bits 1:0 pick the field: 0 source (32 bits), 1 destination (32 bits), 2 count (16 bits, upper write bits dropped), 3 mode (8 bits). Reads are combinational on `cfg_addr`. Unused upper read bits are 0.
- R3: Writing the request register sets each bit written as 1 and leaves the others alone. Writing 0 cancels nothing. A non-burst start makes exactly one transfer, and the channel's bit clears on the edge that completes it. Software can re-arm the channel while its count is non-zero.
- R4: A high `hw_req[n]` arms channel n in the same way. Software and hardware sets in the same cycle are OR-ed together.
- R5: Each transfer decrements the count by one and steps both addresses. Mode bits 1:0 give the size (0 = 1 byte, 1 = 2, 2 or 3 = 4). Bits 3:2 give the source step and bits 5:4 the destination step (0 = increment by size, 1 = decrement by size, 2/3 = fixed). `mem_size` shows 0, 1 or 2.
- R6: With mode bit 6 (burst) set, one start yields back-to-back transfers on that channel until the count reaches zero. `mem_valid` stays high between them.
- R7: When the engine is idle, it grants the lowest-numbered armed channel whose count is non-zero. The grant takes effect on the next edge.
- R8: A start aimed at a channel whose count is zero after that edge is ignored. Such a channel never issues a transfer.
- R9: `done[n]` is high for exactly one cycle, the cycle after the handshake that brings channel n's count to zero. At most one bit is high at a time.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid` and the whole payload stay stable. Writes to the registers of the channel being served are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| hw_req | input | 8 | Hardware start request, one bit per channel |
| mem_valid | output | 1 | Transfer request valid |
| mem_ready | input | 1 | Transfer accepted by the memory side |
| mem_chan | output | 3 | Channel being served |
| mem_src | output | 32 | Source address of the current transfer |
| mem_dst | output | 32 | Destination address of the current transfer |
| mem_size | output | 2 | Item size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| done | output | 8 | One-cycle count-reached-zero pulse per channel |

## Verification
The bench aims at these cases:
- **Writing zero to a busy channel's bit.** A design that treated this as a plain store would drop the pending request.
- **Software and hardware sets in the same cycle.** A design that let one source win would lose a channel.
- **Two channels armed together.** A wrong priority would serve channel 1 ahead of channel 0.
- **Starts on an emptied counter.** A missing gate would underflow the count and run 65535 extra transfers.
- **Burst runs.** A design that released the channel between beats would leave gaps or let another channel in.
- **Register writes during a stalled transfer.** A design that let these through would change an address while `mem_valid` waits.
- **Random back-pressure.** Under `mem_ready` that stalls at random, a cycle-by-cycle model catches any early completion, double step or misplaced done pulse.

// File: rtl/udma_pkg.sv
package udma_pkg;

  typedef enum logic [1:0] {
    F_SRC  = 2'd0,
    F_DST  = 2'd1,
    F_CNT  = 2'd2,
    F_MODE = 2'd3
  } field_e;

  typedef enum logic [1:0] {
    STEP_UP   = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_HOLD = 2'd2,
    STEP_HLD2 = 2'd3
  } step_e;

  typedef struct packed {
    logic       spare;
    logic       burst;
    logic [1:0] dst_step;
    logic [1:0] src_step;
    logic [1:0] size;
  } mode_t;

endpackage

// File: rtl/udma_chan_regs.sv
module udma_chan_regs
  import udma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  field_e            fsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              adv,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [CNT_W-1:0]  cnt,
  output mode_t             mode,
  output logic              nz_next
);

  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] src_d, dst_d;
  logic [CNT_W-1:0]  cnt_d;
  mode_t             mode_d;

  function automatic logic [ADDR_W-1:0] stepped(
    input logic [ADDR_W-1:0] a,
    input logic [1:0]        dir,
    input logic [ADDR_W-1:0] s
  );
    case (step_e'(dir))
      STEP_UP:   return a + s;
      STEP_DOWN: return a - s;
      default:   return a;
    endcase
  endfunction

  always_comb begin
    case (mode.size)
      2'd0:    stride = ADDR_W'(1);
      2'd1:    stride = ADDR_W'(2);
      default: stride = ADDR_W'(4);
    endcase
  end

  always_comb begin
    src_d  = src;
    dst_d  = dst;
    cnt_d  = cnt;
    mode_d = mode;
    if (adv) begin
      src_d = stepped(src, mode.src_step, stride);
      dst_d = stepped(dst, mode.dst_step, stride);
      cnt_d = cnt - CNT_W'(1);
    end else if (wr_en) begin
      case (fsel)
        F_SRC:   src_d  = wdata[ADDR_W-1:0];
        F_DST:   dst_d  = wdata[ADDR_W-1:0];
        F_CNT:   cnt_d  = wdata[CNT_W-1:0];
        default: mode_d = mode_t'(wdata[7:0]);
      endcase
    end
  end

  assign nz_next = (cnt_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      mode <= '0;
    end else begin
      src  <= src_d;
      dst  <= dst_d;
      cnt  <= cnt_d;
      mode <= mode_d;
    end
  end

endmodule

// File: rtl/udma_arb.sv
module udma_arb #(
  parameter int N   = 8,
  localparam int W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         gnt_vld,
  output logic [W-1:0] gnt_idx
);

  always_comb begin
    gnt_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt_idx = W'(i);
    end
  end

  assign gnt_vld = |req;

endmodule

// File: rtl/udma_req_reg.sv
module udma_req_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_sw,
  input  logic [N-1:0] set_hw,
  input  logic [N-1:0] allow,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | ((set_sw | set_hw) & allow);
  end

endmodule

// File: rtl/udma_engine.sv
module udma_engine
  import udma_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CFG_AW = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [NUM_CH-1:0] hw_req,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [CH_W-1:0]   mem_chan,
  output logic [ADDR_W-1:0] mem_src,
  output logic [ADDR_W-1:0] mem_dst,
  output logic [1:0]        mem_size,
  output logic [NUM_CH-1:0] done
);

  logic              busy;
  logic [CH_W-1:0]   cur;
  logic              hs, last, finish;
  logic [NUM_CH-1:0] pend, eligible, nz, nz_next, clr_vec, sw_set;
  logic [NUM_CH-1:0] done_q;
  logic              gnt_vld;
  logic [CH_W-1:0]   gnt_idx;

  logic              is_req;
  logic [CH_W-1:0]   ch_sel;
  field_e            fsel;

  logic [ADDR_W-1:0] src_a [NUM_CH];
  logic [ADDR_W-1:0] dst_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a [NUM_CH];
  mode_t             mode_a[NUM_CH];

  logic [CNT_W-1:0]  cur_cnt;
  mode_t             cur_mode;
  logic              cur_burst;

  // configuration decode
  assign is_req = cfg_addr[CFG_AW-1];
  assign ch_sel = cfg_addr[CH_W+1:2];
  assign fsel   = field_e'(cfg_addr[1:0]);
  assign sw_set = (cfg_wr && is_req) ? cfg_wdata[NUM_CH-1:0] : '0;

  // channel register sets
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic wr_en_n, adv_n;
    assign wr_en_n = cfg_wr && !is_req && (ch_sel == CH_W'(n)) &&
                     !(busy && (cur == CH_W'(n)));
    assign adv_n   = hs && (cur == CH_W'(n));
    udma_chan_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
    ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en_n),
      .fsel   (fsel),
      .wdata  (cfg_wdata),
      .adv    (adv_n),
      .src    (src_a[n]),
      .dst    (dst_a[n]),
      .cnt    (cnt_a[n]),
      .mode   (mode_a[n]),
      .nz_next(nz_next[n])
    );
    assign nz[n] = (cnt_a[n] != '0);
  end

  // request bits
  udma_req_reg #(.N(NUM_CH)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set_sw(sw_set),
    .set_hw(hw_req),
    .allow (nz_next),
    .clr   (clr_vec),
    .pend  (pend)
  );

  assign eligible = pend & nz;

  udma_arb #(.N(NUM_CH)) u_arb (
    .req    (eligible),
    .gnt_vld(gnt_vld),
    .gnt_idx(gnt_idx)
  );

  // serving state
  assign cur_cnt   = cnt_a[cur];
  assign cur_mode  = mode_a[cur];
  assign cur_burst = cur_mode.burst;
  assign hs        = busy && mem_ready;
  assign last      = (cur_cnt == CNT_W'(1));
  assign finish    = hs && (!cur_burst || last);

  always_comb begin
    clr_vec = '0;
    if (finish) clr_vec[cur] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
    end else if (hs) begin
      busy <= !finish;
    end else if (!busy && gnt_vld) begin
      busy <= 1'b1;
      cur  <= gnt_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
    end else begin
      done_q <= '0;
      if (hs && last) done_q[cur] <= 1'b1;
    end
  end

  // memory request port
  assign mem_valid = busy;
  assign mem_chan  = cur;
  assign mem_src   = src_a[cur];
  assign mem_dst   = dst_a[cur];
  assign mem_size  = (cur_mode.size == 2'd3) ? 2'd2 : cur_mode.size;
  assign done      = done_q;

  // read-back
  always_comb begin
    cfg_rdata = '0;
    if (is_req) begin
      cfg_rdata[NUM_CH-1:0] = pend;
    end else begin
      case (fsel)
        F_SRC:   cfg_rdata[ADDR_W-1:0] = src_a[ch_sel];
        F_DST:   cfg_rdata[ADDR_W-1:0] = dst_a[ch_sel];
        F_CNT:   cfg_rdata[CNT_W-1:0]  = cnt_a[ch_sel];
        default: cfg_rdata[7:0]        = mode_a[ch_sel];
      endcase
    end
  end

endmodule

// File: rtl/udma_engine_chk.sv
module udma_engine_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [CH_W-1:0]   mem_chan,
  input logic [ADDR_W-1:0] mem_src,
  input logic [ADDR_W-1:0] mem_dst,
  input logic [1:0]        mem_size,
  input logic [NUM_CH-1:0] done,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] eligible,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic              cur_burst
);

  logic [NUM_CH-1:0] low_mask;
  always_comb low_mask = (NUM_CH'(1) << mem_chan) - NUM_CH'(1);

  // R10: payload held while stalled
  a_r10_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_chan) &&
      $stable(mem_src) && $stable(mem_dst) && $stable(mem_size)));

  // R9: single pulse, following a handshake
  a_r9_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));

  a_r9_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |-> $past(mem_valid && mem_ready));

  // R3: completed channel's request bit is clear
  a_r3_done_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |-> ((done & pend) == '0));

  // R7: lowest armed channel granted
  a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> (($past(eligible) & low_mask) == '0));

  // R8: no transfer from an empty counter
  a_r8_no_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (cur_cnt != '0));

  // R6: burst stays on its channel
  a_r6_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && cur_burst && (cur_cnt > CNT_W'(1)))
      |=> (mem_valid && $stable(mem_chan)));

endmodule

bind udma_engine udma_engine_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_chan (mem_chan),
  .mem_src  (mem_src),
  .mem_dst  (mem_dst),
  .mem_size (mem_size),
  .done     (done),
  .pend     (pend),
  .eligible (eligible),
  .cur_cnt  (cur_cnt),
  .cur_burst(cur_burst)
);

// File: tb/udma_engine_test.sv
module udma_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = 6'h20;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  hw_req = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [2:0]  mem_chan;
  logic [31:0] mem_src, mem_dst;
  logic [1:0]  mem_size;
  logic [7:0]  done;

  always #4 clk = ~clk;

  udma_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_chan(mem_chan),
    .mem_src(mem_src), .mem_dst(mem_dst), .mem_size(mem_size), .done(done)
  );

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  localparam logic [5:0] REQ = 6'h20;
  function automatic logic [5:0] ra(input int ch, input int f);
    return 6'((ch << 2) | f);
  endfunction

  // ---------------- reference model ----------------
  bit [31:0] m_src [8];
  bit [31:0] m_dst [8];
  int        m_cnt [8];
  bit [7:0]  m_mode[8];
  bit [7:0]  m_pend, m_done, o_pend, clr, setok, sw, nd;
  bit        m_busy, o_busy;
  int        m_cur, o_cur, c, pi, by, ch;
  bit        pick;

  function automatic bit [31:0] stepf(input bit [31:0] a, input bit [1:0] d, input int s);
    if (d == 2'd0) return a + 32'(s);
    if (d == 2'd1) return a - 32'(s);
    return a;
  endfunction

  function automatic bit [31:0] m_read(input logic [5:0] a);
    int k;
    k = int'(a[4:2]);
    if (a[5]) return {24'b0, m_pend};
    case (a[1:0])
      2'd0: return m_src[k];
      2'd1: return m_dst[k];
      2'd2: return 32'(m_cnt[k]);
      default: return {24'b0, m_mode[k]};
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_mode[i] = 0;
      end
      m_pend = 0; m_done = 0; m_busy = 0; m_cur = 0;
    end else begin
      o_busy = m_busy; o_cur = m_cur; o_pend = m_pend;
      nd = 0; clr = 0; pick = 0; pi = 0;
      if (o_busy && mem_ready) begin
        c = o_cur;
        by = (m_mode[c][1:0] == 0) ? 1 : (m_mode[c][1:0] == 1) ? 2 : 4;
        m_src[c] = stepf(m_src[c], m_mode[c][3:2], by);
        m_dst[c] = stepf(m_dst[c], m_mode[c][5:4], by);
        m_cnt[c] = m_cnt[c] - 1;
        if (m_cnt[c] == 0) nd[c] = 1;
        if (m_cnt[c] == 0 || !m_mode[c][6]) begin clr[c] = 1; m_busy = 0; end
      end else if (!o_busy) begin
        for (int i = 7; i >= 0; i--)
          if (o_pend[i] && m_cnt[i] != 0) begin pick = 1; pi = i; end
        if (pick) begin m_busy = 1; m_cur = pi; end
      end
      sw = 0;
      if (cfg_wr) begin
        if (cfg_addr[5]) sw = cfg_wdata[7:0];
        else begin
          ch = int'(cfg_addr[4:2]);
          if (!(o_busy && o_cur == ch)) begin
            case (cfg_addr[1:0])
              2'd0: m_src[ch] = cfg_wdata;
              2'd1: m_dst[ch] = cfg_wdata;
              2'd2: m_cnt[ch] = int'(cfg_wdata[15:0]);
              default: m_mode[ch] = cfg_wdata[7:0];
            endcase
          end
        end
      end
      setok = 0;
      for (int i = 0; i < 8; i++)
        if ((sw[i] || hw_req[i]) && m_cnt[i] != 0) setok[i] = 1;
      m_pend = (o_pend & ~clr) | setok;
      m_done = nd;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  int hs_cnt[8];
  int done_cnt[8];
  int first_hs[8];
  int last_hs[8];

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(mem_valid == m_busy, "R10 valid vs model", 32'(mem_valid), 32'(m_busy));
      if (m_busy) begin
        chk(mem_chan == 3'(m_cur), "R7 chan vs model", 32'(mem_chan), 32'(m_cur));
        chk(mem_src == m_src[m_cur], "R5 src vs model", mem_src, m_src[m_cur]);
        chk(mem_dst == m_dst[m_cur], "R5 dst vs model", mem_dst, m_dst[m_cur]);
        chk(mem_size == ((m_mode[m_cur][1:0] == 3) ? 2'd2 : m_mode[m_cur][1:0]),
            "R5 size vs model", 32'(mem_size), 32'(m_mode[m_cur][1:0]));
      end
      chk(done == m_done, "R9 done vs model", 32'(done), 32'(m_done));
      chk(cfg_rdata == m_read(cfg_addr), "R2 readback vs model", cfg_rdata, m_read(cfg_addr));
      if (mem_valid && mem_ready) begin
        if (hs_cnt[mem_chan] == 0) first_hs[mem_chan] = cyc;
        last_hs[mem_chan] = cyc;
        hs_cnt[mem_chan]++;
      end
      for (int i = 0; i < 8; i++) if (done[i]) done_cnt[i]++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 0; cfg_addr = REQ;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    cfg_addr = a;
    @(negedge clk);
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
    step();
    cfg_addr = REQ;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] n, input logic [7:0] md);
    wr(ra(ch, 0), s); wr(ra(ch, 1), d); wr(ra(ch, 2), n); wr(ra(ch, 3), {24'b0, md});
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while ((m_busy || m_pend != 0) && k < 300) begin step(); k++; end
    step(); step();
  endtask

  // watchdog
  initial begin
    #1600000;
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  bit [7:0] lfsr = 8'hA5;

  initial begin
    for (int i = 0; i < 8; i++) begin hs_cnt[i] = 0; done_cnt[i] = 0; first_hs[i] = 0; last_hs[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(mem_valid == 1'b0, "R1 valid after reset", 32'(mem_valid), 0);
    chk(done == 8'h00, "R1 done after reset", 32'(done), 0);
    chk(cfg_rdata == 32'h0, "R1 request reg after reset", cfg_rdata, 0);
    step();
    rd_chk(ra(4, 0), 32'h0, "R1 channel src after reset");

    // R2: map and widths
    wr(ra(2, 0), 32'h0000_1000);
    wr(ra(2, 1), 32'h0000_2000);
    wr(ra(2, 2), 32'h0001_2345);
    wr(ra(2, 3), 32'h0000_ABCD);
    rd_chk(ra(2, 0), 32'h1000, "R2 src readback");
    rd_chk(ra(2, 1), 32'h2000, "R2 dst readback");
    rd_chk(ra(2, 2), 32'h2345, "R2 count truncated to 16 bits");
    rd_chk(ra(2, 3), 32'h00CD, "R2 mode truncated to 8 bits");
    wr(ra(2, 2), 32'd3);
    wr(ra(2, 3), 32'h12);     // 4B, src up, dst down

    // R3: software start, no cancel by writing 0
    mem_ready = 0;
    wr(REQ, 32'h04);
    rd_chk(REQ, 32'h04, "R3 request bit set by write");
    @(negedge clk);
    chk(mem_valid && mem_chan == 3'd2, "R3 channel 2 requested", {mem_valid, 28'b0, mem_chan}, 32'h8000_0002);
    chk(mem_size == 2'd2, "R5 size code for 4 bytes", 32'(mem_size), 2);
    step();
    wr(REQ, 32'h00);
    rd_chk(REQ, 32'h04, "R3 writing zero does not cancel");
    mem_ready = 1;
    wait_idle();
    rd_chk(ra(2, 2), 32'd2, "R3 single transfer per start");
    rd_chk(ra(2, 0), 32'h1004, "R5 src increment by 4");
    rd_chk(ra(2, 1), 32'h1FFC, "R5 dst decrement by 4");
    rd_chk(REQ, 32'h00, "R3 bit cleared on completion");
    chk(done_cnt[2] == 0, "R9 no done before zero", 32'(done_cnt[2]), 0);

    // R4: hardware start
    prog(5, 32'h40, 32'h80, 32'd5, 8'h00);
    hw_req = 8'h20; step(); hw_req = 0;
    wait_idle();
    rd_chk(ra(5, 2), 32'd4, "R4 hardware pulse starts one transfer");
    rd_chk(ra(5, 0), 32'h41, "R5 src step 1 byte");

    // R4 OR + R7 priority + R10 write to active channel
    prog(0, 32'h500, 32'h600, 32'd1, 8'h09);  // 2B, src hold, dst up
    prog(1, 32'h700, 32'h800, 32'd2, 8'h00);
    mem_ready = 0;
    cfg_wr = 1; cfg_addr = REQ; cfg_wdata = 32'h01; hw_req = 8'h02;
    step();
    cfg_wr = 0; hw_req = 0;
    rd_chk(REQ, 32'h03, "R4 software and hardware sets OR-ed");
    @(negedge clk);
    chk(mem_valid && mem_chan == 3'd0, "R7 lowest channel first", 32'(mem_chan), 0);
    step();
    wr(ra(0, 0), 32'hDEAD);
    rd_chk(ra(0, 0), 32'h500, "R10 write to active channel discarded");
    @(negedge clk);
    chk(mem_src == 32'h500, "R10 payload stable while stalled", mem_src, 32'h500);
    step();
    mem_ready = 1;
    wait_idle();
    chk(done_cnt[0] == 1, "R9 done pulse on reaching zero", 32'(done_cnt[0]), 1);
    rd_chk(ra(0, 0), 32'h500, "R5 src fixed step");
    rd_chk(ra(0, 1), 32'h602, "R5 dst increment by 2");
    rd_chk(ra(1, 2), 32'd1, "R7 second channel served after first");

    // R6 burst
    prog(3, 32'h900, 32'hA00, 32'd4, 8'h48);  // 1B, src hold, dst up, burst
    wr(REQ, 32'h08);
    wait_idle();
    chk(hs_cnt[3] == 4, "R6 burst runs to zero", 32'(hs_cnt[3]), 4);
    chk(last_hs[3] - first_hs[3] == 3, "R6 burst back to back", 32'(last_hs[3] - first_hs[3]), 3);
    chk(done_cnt[3] == 1, "R9 one done per burst", 32'(done_cnt[3]), 1);
    rd_chk(ra(3, 1), 32'hA04, "R6 burst dst after four beats");
    rd_chk(ra(3, 2), 32'd0, "R6 count zero after burst");

    // R8 zero counter ignores starts
    wr(REQ, 32'h08);
    rd_chk(REQ, 32'h00, "R8 start on empty channel ignored");
    hw_req = 8'h08; step(); hw_req = 0;
    step(); step();
    chk(hs_cnt[3] == 4, "R8 no transfer from empty channel", 32'(hs_cnt[3]), 4);

    // R5 2-byte decrement
    prog(6, 32'h3000, 32'h4000, 32'd2, 8'h25);
    hw_req = 8'h40; step(); hw_req = 0;
    wait_idle();
    rd_chk(ra(6, 0), 32'h2FFE, "R5 src decrement by 2");
    rd_chk(ra(6, 1), 32'h4000, "R5 dst fixed");

    // R3 restart until zero
    wr(REQ, 32'h02);
    wait_idle();
    chk(done_cnt[1] == 1, "R3 restart reaches zero", 32'(done_cnt[1]), 1);
    wr(REQ, 32'h02);
    rd_chk(REQ, 32'h00, "R8 restart after zero ignored");
    chk(hs_cnt[1] == 2, "R3 two transfers total on channel 1", 32'(hs_cnt[1]), 2);

    // mixed back-pressure run, checked against the model each cycle
    prog(4, 32'h8000, 32'h9000, 32'd6, 8'h56);  // 4B, src down, dst down, burst
    prog(7, 32'hC000, 32'hD000, 32'd3, 8'h01);
    prog(5, 32'h40, 32'h80, 32'd4, 8'h43);
    for (int k = 0; k < 150; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0] | lfsr[2];
      hw_req = (k % 9 == 0) ? 8'hB0 : 8'h00;
      step();
    end
    hw_req = 0;
    mem_ready = 1;
    wait_idle();
    rd_chk(ra(4, 2), 32'd0, "R6 burst under back-pressure ends at zero");
    rd_chk(ra(4, 0), 32'h8000 - 32'd24, "R5 src after six 4-byte decrements");

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule